// File: doc/BRIEF.md
# I2C Target with 7/10-bit Address Recognition

This block is the target (slave) side of an I2C bus. It oversamples SCL and SDA with the system clock and recognises START and STOP conditions. It shifts bytes in and out most significant bit first and drives SDA low (open drain) for acknowledges and for transmitted zeros. It answers to one programmable own address, which is either 7 bits or 10 bits wide as set by configuration. It can also answer to the general call address when that option is enabled.

Received data bytes leave on a valid/ready stream. The `rx_valid` output stays high, and `rx_data` stays stable, until `rx_ready` is seen high at a clock edge. The block cannot stretch SCL, so it cannot stall the bus. If a data byte completes while an earlier byte is still waiting, the new byte is not acknowledged and is dropped.

Bytes to transmit are taken from a second valid/ready stream. `tx_ready` pulses for one cycle at the moment a byte is needed, and the byte is consumed if `tx_valid` is high in that cycle. If `tx_valid` is low, all ones are sent instead. Status outputs report bus busy, the transfer direction, end of byte, STOP seen, general call, and a START or STOP that arrives in the middle of a byte.

Top module: `i2c_tgt_top`

## Requirements
- R1: `st_busy` rises after a START (SDA falling while SCL is high) and falls after a STOP (SDA rising while SCL is high). Every STOP gives a one-cycle `st_stop` pulse.
- R2: In 7-bit mode, the first byte after START is acknowledged (SDA held low during the 9th SCL pulse) only when its bits [7:1] equal `cfg_own_addr[6:0]`. Bit 0 selects the direction: 0 means the target receives, 1 means it transmits. On a mismatch, nothing is acknowledged until the next START.
- R3: In 10-bit mode, a write header `11110`,`cfg_own_addr[9:8]`,`0` is acknowledged. A following byte equal to `cfg_own_addr[7:0]` is then acknowledged and the target receives. Any other second byte is not acknowledged.
- R4: In 10-bit mode, a read header `11110`,`cfg_own_addr[9:8]`,`1` is acknowledged, and the target transmits, only after a completed 10-bit write addressing with no STOP in between. Otherwise the read header is not acknowledged.
- R5: With `cfg_gc_en`=1, the byte 0x00 is acknowledged, `st_gc` goes high until the next START or STOP, and the following bytes are received. With `cfg_gc_en`=0, the byte 0x00 is not acknowledged.
- R6: While the target is receiving, each data byte is assembled MSB first, acknowledged, and presented on `rx_data` with `rx_valid`.
- R7: `rx_valid` holds and `rx_data` stays stable until `rx_ready` is high. A data byte that completes while `rx_valid` is still pending is not acknowledged and is dropped.
- R8: While the target is transmitting, one byte is taken through `tx_valid`/`tx_ready` before each byte and sent MSB first; 0xFF is sent if `tx_valid` is low. A master NACK ends the transmission, and SDA stays released until the next START.
- R9: `st_eob` pulses once after the 8th clock of every byte in the address phase or in an addressed transfer, and never for ignored bytes. `st_tra` is high exactly while the target is the transmitter.
- R10: A START or STOP while busy, after at least two SCL rises of the current byte (including its acknowledge clock), pulses `st_misplaced`. It also aborts the transfer: SDA is released, and the block restarts address decoding on START or goes idle on STOP.
- R11: `sda_oe` only turns on while the synchronised SCL is low, and it is always off when the bus is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| cfg_own_addr | input | ADDR_W (10) | Own address; only [6:0] is used in 7-bit mode |
| cfg_ten_bit | input | 1 | 1 selects 10-bit addressing |
| cfg_gc_en | input | 1 | Enables general call recognition |
| tx_data | input | DATA_W (8) | Byte to transmit |
| tx_valid | input | 1 | `tx_data` is available |
| tx_ready | output | 1 | Target takes a byte this cycle |
| rx_data | output | DATA_W (8) | Last received byte |
| rx_valid | output | 1 | `rx_data` is pending |
| rx_ready | input | 1 | Consumer takes `rx_data` |
| st_busy | output | 1 | Bus between START and STOP |
| st_tra | output | 1 | Target is transmitter |
| st_eob | output | 1 | End-of-byte pulse |
| st_stop | output | 1 | STOP-seen pulse |
| st_misplaced | output | 1 | Misplaced START/STOP pulse |
| st_gc | output | 1 | Addressed by general call |

## Verification
A STOP that arrives partway through a byte must raise the stop-detected pulse and the misplaced-condition pulse in the same cycle, and it must also clear busy. The bench provokes this by clocking three data bits after a valid address and then issuing a STOP. It judges the result through pulse counters kept on the status outputs, which must both advance by one, and through `st_busy`, which must read zero. A misplaced repeated START is also driven mid-byte. The address byte that follows it must then be acknowledged as if the bus had been idle.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR1,
    PH_ADDR2,
    PH_RX,
    PH_TX,
    PH_SKIP
  } phase_t;

  localparam logic [4:0] TEN_BIT_TAG = 5'b11110;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic sda_hi,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_cond,
  output logic stop_cond
);
  // STAGES synchroniser flops plus one history flop per line
  logic [STAGES:0] scl_q;
  logic [STAGES:0] sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[STAGES-1:0], scl_i};
      sda_q <= {sda_q[STAGES-1:0], sda_i};
    end
  end

  assign scl_hi     = scl_q[STAGES-1];
  assign sda_hi     = sda_q[STAGES-1];
  assign scl_rise   =  scl_q[STAGES-1] & ~scl_q[STAGES];
  assign scl_fall   = ~scl_q[STAGES-1] &  scl_q[STAGES];
  assign start_cond =  scl_q[STAGES-1] &  scl_q[STAGES] & sda_q[STAGES] & ~sda_q[STAGES-1];
  assign stop_cond  =  scl_q[STAGES-1] &  scl_q[STAGES] & ~sda_q[STAGES] & sda_q[STAGES-1];

endmodule

// File: rtl/i2c_tgt_bitctr.sv
module i2c_tgt_bitctr #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_hi,
  input  logic              restart,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [DATA_W-1:0] shift_byte,
  output logic              byte_done,
  output logic              ack_rise,
  output logic              ack_end,
  output logic              mid_byte
);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ACK_IDX   = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] MID_MIN   = CNT_W'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      shift_byte <= '0;
    end else if (restart) begin
      bit_cnt <= '0;
    end else if (scl_rise) begin
      if (bit_cnt < LAST_DATA) shift_byte <= {shift_byte[DATA_W-2:0], sda_hi};
      if (bit_cnt != ACK_IDX) bit_cnt <= bit_cnt + 1'b1;
    end else if (scl_fall && bit_cnt == ACK_IDX) begin
      bit_cnt <= '0;
    end
  end

  assign byte_done = scl_fall & (bit_cnt == LAST_DATA);
  assign ack_rise  = scl_rise & (bit_cnt == LAST_DATA);
  assign ack_end   = scl_fall & (bit_cnt == ACK_IDX);
  assign mid_byte  = (bit_cnt >= MID_MIN);

endmodule

// File: rtl/i2c_tgt_match.sv
module i2c_tgt_match
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10,
  localparam int HI_W = ADDR_W - DATA_W
) (
  input  logic [DATA_W-1:0] byte_in,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ten_bit,
  input  logic              gc_en,
  output logic              m7_hit,
  output logic              hi_hit,
  output logic              lo_hit,
  output logic              gc_hit,
  output logic              rw_bit
);
  assign rw_bit = byte_in[0];
  assign m7_hit = ~ten_bit & (byte_in[DATA_W-1:1] == own_addr[DATA_W-2:0]);
  assign hi_hit =  ten_bit & (byte_in[DATA_W-1:HI_W+1] == TEN_BIT_TAG)
                           & (byte_in[HI_W:1] == own_addr[ADDR_W-1:DATA_W]);
  assign lo_hit = (byte_in == own_addr[DATA_W-1:0]);
  assign gc_hit = gc_en & (byte_in == '0);

endmodule

// File: rtl/i2c_tgt_top.sv
module i2c_tgt_top
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] cfg_own_addr,
  input  logic              cfg_ten_bit,
  input  logic              cfg_gc_en,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              st_busy,
  output logic              st_tra,
  output logic              st_eob,
  output logic              st_stop,
  output logic              st_misplaced,
  output logic              st_gc
);
  logic scl_hi, sda_hi, scl_rise, scl_fall, start_cond, stop_cond;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shift_byte;
  logic byte_done, ack_rise, ack_end, mid_byte;
  logic m7_hit, hi_hit, lo_hit, gc_hit, rw_bit;
  phase_t            phase;
  logic              ten_armed;
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] tx_word;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_hi(scl_hi), .sda_hi(sda_hi), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_cond(start_cond), .stop_cond(stop_cond)
  );

  i2c_tgt_bitctr #(.DATA_W(DATA_W)) bits_i (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_hi(sda_hi), .restart(start_cond | stop_cond),
    .bit_cnt(bit_cnt), .shift_byte(shift_byte), .byte_done(byte_done),
    .ack_rise(ack_rise), .ack_end(ack_end), .mid_byte(mid_byte)
  );

  i2c_tgt_match #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) match_i (
    .byte_in(shift_byte), .own_addr(cfg_own_addr), .ten_bit(cfg_ten_bit),
    .gc_en(cfg_gc_en), .m7_hit(m7_hit), .hi_hit(hi_hit), .lo_hit(lo_hit),
    .gc_hit(gc_hit), .rw_bit(rw_bit)
  );

  assign tx_word  = tx_valid ? tx_data : '1;
  assign tx_ready = ack_end & (phase == PH_TX);
  assign st_tra   = (phase == PH_TX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= PH_IDLE;
      ten_armed    <= 1'b0;
      sda_oe       <= 1'b0;
      tx_sr        <= '1;
      rx_data      <= '0;
      rx_valid     <= 1'b0;
      st_busy      <= 1'b0;
      st_eob       <= 1'b0;
      st_stop      <= 1'b0;
      st_misplaced <= 1'b0;
      st_gc        <= 1'b0;
    end else begin
      st_eob       <= 1'b0;
      st_stop      <= 1'b0;
      st_misplaced <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;

      if (start_cond) begin
        st_busy <= 1'b1;
        phase   <= PH_ADDR1;
        sda_oe  <= 1'b0;
        st_gc   <= 1'b0;
        if (st_busy && mid_byte) st_misplaced <= 1'b1;
      end else if (stop_cond) begin
        st_busy   <= 1'b0;
        phase     <= PH_IDLE;
        sda_oe    <= 1'b0;
        st_gc     <= 1'b0;
        ten_armed <= 1'b0;
        st_stop   <= 1'b1;
        if (st_busy && mid_byte) st_misplaced <= 1'b1;
      end else if (byte_done) begin
        sda_oe <= 1'b0;
        if (phase inside {PH_ADDR1, PH_ADDR2, PH_RX, PH_TX}) st_eob <= 1'b1;
        case (phase)
          PH_ADDR1: begin
            if (gc_hit) begin
              sda_oe <= 1'b1; phase <= PH_RX; st_gc <= 1'b1; ten_armed <= 1'b0;
            end else if (m7_hit) begin
              sda_oe <= 1'b1; phase <= rw_bit ? PH_TX : PH_RX; ten_armed <= 1'b0;
            end else if (hi_hit && !rw_bit) begin
              sda_oe <= 1'b1; phase <= PH_ADDR2;
            end else if (hi_hit && ten_armed) begin
              sda_oe <= 1'b1; phase <= PH_TX;
            end else begin
              phase <= PH_SKIP; ten_armed <= 1'b0;
            end
          end
          PH_ADDR2: begin
            if (lo_hit) begin
              sda_oe <= 1'b1; phase <= PH_RX; ten_armed <= 1'b1;
            end else begin
              phase <= PH_SKIP; ten_armed <= 1'b0;
            end
          end
          PH_RX: begin
            if (!rx_valid || rx_ready) begin
              rx_data  <= shift_byte;
              rx_valid <= 1'b1;
              sda_oe   <= 1'b1;
            end
          end
          default: ;
        endcase
      end else if (ack_rise) begin
        if (phase == PH_TX && sda_hi) phase <= PH_SKIP;
      end else if (ack_end) begin
        sda_oe <= 1'b0;
        if (phase == PH_TX) begin
          sda_oe <= ~tx_word[DATA_W-1];
          tx_sr  <= {tx_word[DATA_W-2:0], 1'b1};
        end
      end else if (scl_fall && phase == PH_TX && bit_cnt != '0) begin
        sda_oe <= ~tx_sr[DATA_W-1];
        tx_sr  <= {tx_sr[DATA_W-2:0], 1'b1};
      end
    end
  end

endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_cond,
  input logic              stop_cond,
  input logic              scl_hi,
  input logic              sda_oe,
  input logic              st_busy,
  input logic              st_stop,
  input logic              st_tra,
  input logic              st_eob,
  input logic              st_misplaced,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data
);
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_cond |=> st_busy);                                        // R1
  AST_STOP_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cond |=> (st_stop && !st_busy));                           // R1
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));    // R7
  AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !$past(sda_oe)) |-> !scl_hi);                        // R11
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !st_busy |-> !sda_oe);                                          // R11
  AST_TRA_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    st_tra |-> st_busy);                                            // R9
  AST_EOB_NOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_eob, st_stop}));                                   // R9
  AST_MISPLACED_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    st_misplaced |-> !sda_oe);                                      // R10
endmodule

bind i2c_tgt_top i2c_tgt_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_cond(start_cond), .stop_cond(stop_cond),
  .scl_hi(scl_hi), .sda_oe(sda_oe), .st_busy(st_busy), .st_stop(st_stop),
  .st_tra(st_tra), .st_eob(st_eob), .st_misplaced(st_misplaced),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
);

// File: tb/i2c_tgt_top_tb.sv
module i2c_tgt_top_tb_top;
  localparam int Q = 8;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic scl_m = 1'b1, sda_low = 1'b0;
  logic sda_oe, sda_bus;
  logic [9:0] own = 10'h03A;
  logic ten = 1'b0, gc_en = 1'b0;
  logic [7:0] tx_data, rx_data;
  logic tx_valid = 1'b1, tx_ready, rx_valid, rx_ready = 1'b1;
  logic st_busy, st_tra, st_eob, st_stop, st_misplaced, st_gc;

  assign sda_bus = ~(sda_low | sda_oe);

  i2c_tgt_top dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .cfg_own_addr(own), .cfg_ten_bit(ten), .cfg_gc_en(gc_en),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .st_busy(st_busy), .st_tra(st_tra), .st_eob(st_eob), .st_stop(st_stop),
    .st_misplaced(st_misplaced), .st_gc(st_gc)
  );

  int nvec = 0, nerr = 0;
  int eob_cnt = 0, stop_cnt = 0, mis_cnt = 0;
  int tx_taken = 0, rd_cnt = 0;
  logic [7:0] rx_last = 8'h00;
  logic [7:0] txbuf [16];
  bit done = 1'b0;

  assign tx_data = txbuf[tx_taken % 16];

  always @(posedge clk) begin
    if (st_eob) eob_cnt++;
    if (st_stop) stop_cnt++;
    if (st_misplaced) mis_cnt++;
    if (rx_valid && rx_ready) rx_last <= rx_data;
    if (tx_valid && tx_ready) tx_taken++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c();          // from idle bus
    sda_low = 1'b1; tick(Q); scl_m = 1'b0;
  endtask

  task automatic rstart_c();         // SCL low on entry
    tick(H); sda_low = 1'b0; tick(H); scl_m = 1'b1; tick(Q);
    sda_low = 1'b1; tick(Q); scl_m = 1'b0;
  endtask

  task automatic stop_c();           // SCL low on entry
    tick(H); sda_low = 1'b1; tick(H); scl_m = 1'b1; tick(Q);
    sda_low = 1'b0; tick(Q);
  endtask

  task automatic wbit(logic b);
    tick(H); sda_low = ~b; tick(H); scl_m = 1'b1; tick(Q); scl_m = 1'b0;
  endtask

  task automatic wbyte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    tick(H); sda_low = 1'b0; tick(H); scl_m = 1'b1; tick(H);
    ack = ~sda_bus; tick(H); scl_m = 1'b0;
  endtask

  task automatic rbyte(logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(H); sda_low = 1'b0; tick(H); scl_m = 1'b1; tick(H);
      b[i] = sda_bus; tick(H); scl_m = 1'b0;
    end
    tick(H); sda_low = mack; tick(H); scl_m = 1'b1; tick(Q); scl_m = 1'b0;
  endtask

  function automatic logic exp_ack7(logic [7:0] b);
    return (b[7:1] == own[6:0]) || (gc_en && b == 8'h00);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b, d;
    int e0, s0, m0;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 16; i++) txbuf[i] = 8'($urandom);
    tick(4);
    rst_n = 1'b1;
    tick(4);
    chk("R1 reset busy", st_busy, 0);
    chk("R11 reset sda_oe", sda_oe, 0);
    chk("R6 reset rx_valid", rx_valid, 0);
    chk("R9 reset tra", st_tra, 0);

    // 7-bit write
    e0 = eob_cnt; s0 = stop_cnt;
    start_c(); tick(4);
    chk("R1 busy after start", st_busy, 1);
    wbyte({7'h3A, 1'b0}, ack); chk("R2 own write ack", ack, 1);
    chk("R9 tra receive", st_tra, 0);
    wbyte(8'hA5, ack); chk("R6 data ack", ack, 1);
    chk("R6 data", rx_last, 8'hA5);
    stop_c(); tick(2);
    chk("R1 busy after stop", st_busy, 0);
    chk("R1 stop pulse", stop_cnt - s0, 1);
    chk("R9 eob count", eob_cnt - e0, 2);

    // 7-bit mismatch
    e0 = eob_cnt;
    start_c();
    wbyte({7'h3B, 1'b0}, ack); chk("R2 other addr nack", ack, 0);
    wbyte(8'h00, ack); chk("R2 ignored data nack", ack, 0);
    stop_c();
    chk("R9 no eob for ignored", eob_cnt - e0, 1);

    // 7-bit read
    start_c();
    wbyte({7'h3A, 1'b1}, ack); chk("R2 own read ack", ack, 1);
    chk("R9 tra transmit", st_tra, 1);
    rbyte(1'b1, b); chk("R8 tx byte0", b, txbuf[rd_cnt % 16]); rd_cnt++;
    rbyte(1'b0, b); chk("R8 tx byte1", b, txbuf[rd_cnt % 16]); rd_cnt++;
    tick(2); chk("R8 nack ends tx", st_tra, 0);
    chk("R8 released after nack", sda_oe, 0);
    stop_c();

    // underrun
    tx_valid = 1'b0;
    start_c();
    wbyte({7'h3A, 1'b1}, ack);
    rbyte(1'b0, b); chk("R8 underrun ff", b, 8'hFF);
    stop_c();
    tx_valid = 1'b1;

    // random 7-bit traffic
    for (int it = 0; it < 40; it++) begin
      logic [6:0] a;
      logic rw, ea;
      int n;
      a  = ($urandom % 2) ? own[6:0] : 7'($urandom);
      rw = 1'($urandom);
      n  = 1 + ($urandom % 3);
      ea = exp_ack7({a, rw});
      start_c();
      wbyte({a, rw}, ack); chk("R2 random addr ack", ack, ea);
      for (int j = 0; j < n; j++) begin
        if (!rw) begin
          d = 8'($urandom);
          wbyte(d, ack); chk("R6 random data ack", ack, ea);
          if (ea) chk("R6 random data", rx_last, d);
        end else begin
          rbyte(j != n - 1, b);
          if (ea) begin
            chk("R8 random tx", b, txbuf[rd_cnt % 16]); rd_cnt++;
          end else chk("R8 unaddressed read", b, 8'hFF);
        end
      end
      stop_c();
    end

    // general call
    gc_en = 1'b1;
    start_c();
    wbyte(8'h00, ack); chk("R5 gc ack", ack, 1);
    chk("R5 gc flag", st_gc, 1);
    wbyte(8'h3C, ack); chk("R5 gc data", rx_last, 8'h3C);
    stop_c(); tick(2);
    chk("R5 gc flag cleared", st_gc, 0);
    gc_en = 1'b0;
    start_c();
    wbyte(8'h00, ack); chk("R5 gc disabled nack", ack, 0);
    stop_c();

    // 10-bit
    ten = 1'b1; own = 10'h2C5;
    start_c();
    wbyte({5'b11110, 2'b10, 1'b0}, ack); chk("R3 header ack", ack, 1);
    wbyte(8'hC5, ack); chk("R3 low byte ack", ack, 1);
    wbyte(8'h5A, ack); chk("R3 data", rx_last, 8'h5A);
    rstart_c();
    wbyte({5'b11110, 2'b10, 1'b1}, ack); chk("R4 read header ack", ack, 1);
    chk("R4 tra", st_tra, 1);
    rbyte(1'b0, b); chk("R4 tx data", b, txbuf[rd_cnt % 16]); rd_cnt++;
    stop_c();
    start_c();
    wbyte({5'b11110, 2'b10, 1'b1}, ack); chk("R4 unarmed read nack", ack, 0);
    stop_c();
    start_c();
    wbyte({5'b11110, 2'b10, 1'b0}, ack);
    wbyte(8'hC4, ack); chk("R3 wrong low nack", ack, 0);
    stop_c();
    ten = 1'b0; own = 10'h03A;

    // back-pressure
    rx_ready = 1'b0;
    start_c();
    wbyte({7'h3A, 1'b0}, ack);
    wbyte(8'h11, ack); chk("R7 first ack", ack, 1);
    wbyte(8'h22, ack); chk("R7 overrun nack", ack, 0);
    chk("R7 held valid", rx_valid, 1);
    chk("R7 held data", rx_data, 8'h11);
    stop_c();
    rx_ready = 1'b1; tick(2);
    chk("R7 drained", rx_last, 8'h11);

    // misplaced STOP, coinciding with stop pulse
    s0 = stop_cnt; m0 = mis_cnt;
    start_c();
    wbyte({7'h3A, 1'b0}, ack);
    wbit(1'b1); wbit(1'b0); wbit(1'b1);
    stop_c(); tick(2);
    chk("R10 misplaced stop", mis_cnt - m0, 1);
    chk("R1 stop with misplaced", stop_cnt - s0, 1);
    chk("R10 busy cleared", st_busy, 0);

    // misplaced START
    m0 = mis_cnt;
    start_c();
    wbyte({7'h3A, 1'b0}, ack);
    wbit(1'b0); wbit(1'b1); wbit(1'b0); wbit(1'b0);
    rstart_c();
    chk("R10 misplaced start", mis_cnt - m0, 1);
    wbyte({7'h3A, 1'b0}, ack); chk("R10 readdressed ack", ack, 1);
    wbyte(8'h77, ack); chk("R10 data after abort", rx_last, 8'h77);
    stop_c(); tick(2);
    chk("R10 normal stop no error", mis_cnt - m0, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule